// File: doc/BRIEF.md
# Processor Power-State Controller

This block steps a processor core between three power states: full-speed RUN, a shallow IDLE and a deep SLEEP. Software or a scheduler asks for a low-power state and supplies a predicted idle time in clock cycles. Before the controller commits, it checks whether that idle time is long enough to repay the energy spent waking up again. A request that fails this check is demoted to the next shallower state, or dropped if even IDLE would not pay off. IDLE is left when an interrupt arrives. SLEEP is left only on a dedicated wake event.

Every transition takes its own number of cycles, and the two directions need not match. While a transition is in progress the controller keeps reporting the state it is leaving and raises a busy flag. The new state appears when the flag drops. A request that arrives during a transition is held in one slot and served once the core is back in RUN and the controller is no longer busy. Latencies and power figures are parameters. The break-even thresholds are computed from them at elaboration.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `state_o` is 0 (RUN) and `busy_o` is 0.
- R2: `state_o` encodes RUN=0, IDLE=1 and SLEEP=2, and never shows 3. Throughout a transition `busy_o` is 1 and `state_o` keeps the source state. The destination appears in the same cycle that `busy_o` returns to 0.
- R3: In RUN while not busy, a request with `req_target`=1 and `pred_idle` ≥ TH_IDLE raises `busy_o` one cycle later. `busy_o` stays high for LAT_RUN_IDLE cycles and the controller then lands in IDLE.
- R4: In RUN while not busy, a request with `req_target`=2 and `pred_idle` ≥ TH_SLEEP is busy for LAT_RUN_SLEEP cycles and then lands in SLEEP.
- R5: A `req_target`=2 request whose `pred_idle` is at least TH_IDLE but below TH_SLEEP is carried out as an IDLE entry. A request of either target whose `pred_idle` is below TH_IDLE leaves the controller in RUN with `busy_o` low.
- R6: IDLE is left only when `irq` is 1 while not busy. The return to RUN takes LAT_IDLE_RUN busy cycles, and `wake` has no effect in IDLE.
- R7: SLEEP is left only when `wake` is 1 while not busy. The return to RUN takes LAT_SLEEP_RUN busy cycles, and `irq` has no effect in SLEEP.
- R8: Each threshold is max(0, ceil((P_wake − P_RUN) × L_wake / (P_RUN − P_low))) cycles. Here P_wake is the power drawn while returning to RUN, L_wake is that return latency and P_low is the power of the target state. A `pred_idle` equal to the threshold passes, and one cycle less fails.
- R9: A request presented while `busy_o` is 1 is held, and a later one overwrites it. The held request is evaluated in the first not-busy cycle in RUN and takes priority over a live request in that cycle. The hold is then cleared.
- R10: A request presented in steady IDLE or SLEEP (not busy) is discarded. A `req_target` of 0 or 3 never starts a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Low-power request strobe |
| req_target | input | 2 | Requested state: 1 IDLE, 2 SLEEP |
| pred_idle | input | PRED_W | Predicted idle duration in cycles |
| irq | input | 1 | Interrupt, exits IDLE |
| wake | input | 1 | Wake event, exits SLEEP |
| state_o | output | 2 | Current (or source) power state |
| busy_o | output | 1 | Transition in progress |

## Verification
The bench sets the four latencies to 3, 4, 5 and 7 cycles and keeps the default power figures. These values give TH_IDLE = 3 and TH_SLEEP = 8. Both break-even edges, the SLEEP-to-IDLE demotion and the full wake path can therefore be tested inside a few dozen cycles, while the default 1600-cycle wake stays untouched. Because each latency is distinct, a mixed-up latency selection shows up as a wrong busy-cycle count. The held-request test then checks that the stored request fires exactly one cycle after the controller lands back in RUN.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_IDLE  = 2'd1,
      PS_SLEEP = 2'd2
   } pstate_e;

   // Break-even residency in cycles: max(0, ceil((p_wake - p_hi) * lat / (p_hi - p_lo)))
   function automatic longint breakeven_cycles(input longint p_hi, input longint p_lo,
                                               input longint p_wake, input longint lat);
      longint num;
      longint den;
      if (p_wake <= p_hi) return 0;
      num = (p_wake - p_hi) * lat;
      den = p_hi - p_lo;
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pse_breakeven.sv
module pse_breakeven
   import pwr_state_pkg::*;
#(
   parameter int           PRED_W   = 16,
   parameter logic [63:0]  TH_IDLE  = 64'd0,
   parameter logic [63:0]  TH_SLEEP = 64'd0
) (
   input  logic [1:0]        tgt_i,
   input  logic [PRED_W-1:0] pred_i,
   output logic              go_o,
   output pstate_e           dst_o
);

   logic [63:0] pred_ext;
   logic        fits_idle;
   logic        fits_sleep;

   assign pred_ext   = {{(64-PRED_W){1'b0}}, pred_i};
   assign fits_idle  = (pred_ext >= TH_IDLE);
   assign fits_sleep = (pred_ext >= TH_SLEEP);

   always_comb begin
      go_o  = 1'b0;
      dst_o = PS_RUN;
      case (tgt_i)
         2'd2: begin
            if (fits_sleep) begin
               go_o  = 1'b1;
               dst_o = PS_SLEEP;
            end else if (fits_idle) begin
               go_o  = 1'b1;
               dst_o = PS_IDLE;
            end
         end
         2'd1: begin
            if (fits_idle) begin
               go_o  = 1'b1;
               dst_o = PS_IDLE;
            end
         end
         default: begin
            go_o  = 1'b0;
            dst_o = PS_RUN;
         end
      endcase
   end

endmodule

// File: rtl/pse_lat_timer.sv
module pse_lat_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             busy_o,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pse_req_hold.sv
module pse_req_hold #(
   parameter int PRED_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              consume_i,
   input  logic [1:0]        tgt_i,
   input  logic [PRED_W-1:0] pred_i,
   output logic              vld_o,
   output logic [1:0]        tgt_o,
   output logic [PRED_W-1:0] pred_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         tgt_o  <= 2'd0;
         pred_o <= '0;
      end else if (capture_i) begin
         vld_o  <= 1'b1;
         tgt_o  <= tgt_i;
         pred_o <= pred_i;
      end else if (consume_i) begin
         vld_o  <= 1'b0;
      end
   end

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_state_pkg::*;
#(
   parameter int     PRED_W          = 16,
   parameter int     LAT_RUN_IDLE    = 10,
   parameter int     LAT_IDLE_RUN    = 10,
   parameter int     LAT_RUN_SLEEP   = 90,
   parameter int     LAT_SLEEP_RUN   = 1600,
   parameter longint P_RUN_UW        = 400000,
   parameter longint P_IDLE_UW       = 50000,
   parameter longint P_SLEEP_UW      = 160,
   parameter longint P_IDLE_WAKE_UW  = 600000,
   parameter longint P_SLEEP_WAKE_UW = 800000,
   parameter bit     BREAK_EVEN_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_target,
   input  logic [PRED_W-1:0] pred_idle,
   input  logic              irq,
   input  logic              wake,
   output logic [1:0]        state_o,
   output logic              busy_o
);

   localparam int LAT_MAX = max2(max2(LAT_RUN_IDLE, LAT_IDLE_RUN),
                                 max2(LAT_RUN_SLEEP, LAT_SLEEP_RUN));
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   localparam longint TH_IDLE_RAW  = breakeven_cycles(P_RUN_UW, P_IDLE_UW,
                                                      P_IDLE_WAKE_UW, longint'(LAT_IDLE_RUN));
   localparam longint TH_SLEEP_RAW = breakeven_cycles(P_RUN_UW, P_SLEEP_UW,
                                                      P_SLEEP_WAKE_UW, longint'(LAT_SLEEP_RUN));
   localparam logic [63:0] TH_IDLE  = BREAK_EVEN_EN ? 64'(TH_IDLE_RAW)  : 64'd0;
   localparam logic [63:0] TH_SLEEP = BREAK_EVEN_EN ? 64'(TH_SLEEP_RAW) : 64'd0;

   localparam logic [CNT_W-1:0] L_RI = CNT_W'(LAT_RUN_IDLE);
   localparam logic [CNT_W-1:0] L_IR = CNT_W'(LAT_IDLE_RUN);
   localparam logic [CNT_W-1:0] L_RS = CNT_W'(LAT_RUN_SLEEP);
   localparam logic [CNT_W-1:0] L_SR = CNT_W'(LAT_SLEEP_RUN);

   // Elaboration-time parameter checks
   if (PRED_W < 1 || PRED_W > 63) begin : g_bad_pred_w
      $error("pwr_state_ctrl: PRED_W must lie in 1..63");
   end
   if (LAT_RUN_IDLE < 1 || LAT_IDLE_RUN < 1 || LAT_RUN_SLEEP < 1 || LAT_SLEEP_RUN < 1)
   begin : g_bad_lat
      $error("pwr_state_ctrl: every transition latency must be at least one cycle");
   end
   if (P_RUN_UW <= P_IDLE_UW || P_RUN_UW <= P_SLEEP_UW) begin : g_bad_pwr
      $error("pwr_state_ctrl: low-power states must draw less than RUN");
   end

   pstate_e          state_q;
   pstate_e          dst_q;
   pstate_e          nxt_dst;
   logic             start;
   logic [CNT_W-1:0] load_val;
   logic             tmr_busy;
   logic             tmr_done;

   logic              hold_vld;
   logic [1:0]        hold_tgt;
   logic [PRED_W-1:0] hold_pred;
   logic              hold_capture;
   logic              hold_consume;

   logic [1:0]        sel_tgt;
   logic [PRED_W-1:0] sel_pred;
   logic              sel_valid;
   logic              be_go;
   pstate_e           be_dst;

   logic run_free;

   assign run_free     = (state_q == PS_RUN) && !tmr_busy;
   assign hold_capture = tmr_busy && req_valid;
   assign hold_consume = run_free && hold_vld;

   assign sel_valid = hold_vld | req_valid;
   assign sel_tgt   = hold_vld ? hold_tgt  : req_target;
   assign sel_pred  = hold_vld ? hold_pred : pred_idle;

   pse_req_hold #(
      .PRED_W (PRED_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (hold_capture),
      .consume_i (hold_consume),
      .tgt_i     (req_target),
      .pred_i    (pred_idle),
      .vld_o     (hold_vld),
      .tgt_o     (hold_tgt),
      .pred_o    (hold_pred)
   );

   pse_breakeven #(
      .PRED_W   (PRED_W),
      .TH_IDLE  (TH_IDLE),
      .TH_SLEEP (TH_SLEEP)
   ) u_be (
      .tgt_i  (sel_tgt),
      .pred_i (sel_pred),
      .go_o   (be_go),
      .dst_o  (be_dst)
   );

   always_comb begin
      start    = 1'b0;
      nxt_dst  = PS_RUN;
      load_val = L_RI;
      if (!tmr_busy) begin
         case (state_q)
            PS_RUN: begin
               if (sel_valid && be_go) begin
                  start    = 1'b1;
                  nxt_dst  = be_dst;
                  load_val = (be_dst == PS_SLEEP) ? L_RS : L_RI;
               end
            end
            PS_IDLE: begin
               if (irq) begin
                  start    = 1'b1;
                  nxt_dst  = PS_RUN;
                  load_val = L_IR;
               end
            end
            PS_SLEEP: begin
               if (wake) begin
                  start    = 1'b1;
                  nxt_dst  = PS_RUN;
                  load_val = L_SR;
               end
            end
            default: begin
               start = 1'b0;
            end
         endcase
      end
   end

   pse_lat_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start),
      .load_val_i (load_val),
      .busy_o     (tmr_busy),
      .done_o     (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         dst_q   <= PS_RUN;
      end else begin
         if (start)    dst_q   <= nxt_dst;
         if (tmr_done) state_q <= dst_q;
      end
   end

   assign state_o = state_q;
   assign busy_o  = tmr_busy;

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq,
   input logic       wake,
   input logic [1:0] state_o,
   input logic       busy_o
);

   p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd3);

   p_src_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(state_o));

   p_land_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (state_o != $past(state_o)));

   p_run_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && !busy_o) |=> (state_o == 2'd0));

   p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && !busy_o && !irq) |=> (state_o == 2'd1 && !busy_o));

   p_idle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && !busy_o && irq) |=> (state_o == 2'd1 && busy_o));

   p_sleep_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && !busy_o && !wake) |=> (state_o == 2'd2 && !busy_o));

   p_sleep_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && !busy_o && wake) |=> (state_o == 2'd2 && busy_o));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .wake    (wake),
   .state_o (state_o),
   .busy_o  (busy_o)
);

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;

   localparam int L_RI = 3;
   localparam int L_IR = 4;
   localparam int L_RS = 5;
   localparam int L_SR = 7;
   // Expected break-even thresholds with default powers:
   // idle  = ceil(200000*4/350000)  = 3
   // sleep = ceil(400000*7/399840)  = 8

   typedef struct packed {
      logic [1:0]  tgt;
      logic [15:0] pred;
      logic [1:0]  dst;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 16'd3,     2'd1},   // R8 idle threshold met exactly
      '{2'd1, 16'd2,     2'd0},   // R8 one below idle threshold
      '{2'd2, 16'd8,     2'd2},   // R8 sleep threshold met exactly
      '{2'd2, 16'd7,     2'd1},   // R5 demoted to IDLE
      '{2'd2, 16'd2,     2'd0},   // R5 dropped entirely
      '{2'd1, 16'd100,   2'd1},   // R3
      '{2'd0, 16'd100,   2'd0},   // R10 target code 0
      '{2'd3, 16'd100,   2'd0},   // R10 target code 3
      '{2'd2, 16'hFFFF,  2'd2}    // R4 long prediction
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_target = 2'd0;
   logic [15:0] pred_idle = 16'd0;
   logic        irq = 1'b0;
   logic        wake = 1'b0;
   logic [1:0]  state_o;
   logic        busy_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pwr_state_ctrl #(
      .PRED_W        (16),
      .LAT_RUN_IDLE  (L_RI),
      .LAT_IDLE_RUN  (L_IR),
      .LAT_RUN_SLEEP (L_RS),
      .LAT_SLEEP_RUN (L_SR)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_target (req_target),
      .pred_idle  (pred_idle),
      .irq        (irq),
      .wake       (wake),
      .state_o    (state_o),
      .busy_o     (busy_o)
   );

   task automatic chk(input logic eb, input logic [1:0] es, input string tag);
      n_chk++;
      if (busy_o !== eb || state_o !== es) begin
         n_err++;
         $display("FAIL %s: busy=%0b state=%0d, expected busy=%0b state=%0d",
                  tag, busy_o, state_o, eb, es);
      end
   endtask

   // Checks nb busy samples showing src, then the landing sample showing dst.
   task automatic expect_trans(input int nb, input logic [1:0] src, input logic [1:0] dst,
                               input string tag);
      for (int i = 0; i < nb; i++) begin
         chk(1'b1, src, tag);
         @(negedge clk);
      end
      chk(1'b0, dst, tag);
   endtask

   task automatic quiet(input int n, input logic [1:0] st, input string tag);
      for (int i = 0; i < n; i++) begin
         chk(1'b0, st, tag);
         @(negedge clk);
      end
   endtask

   task automatic send_req(input logic [1:0] t, input logic [15:0] p);
      req_valid  = 1'b1;
      req_target = t;
      pred_idle  = p;
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic pulse_irq();
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(1'b0, 2'd0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b0, 2'd0, "R1 after reset release");

      // Vector walk, always starting from RUN
      for (int i = 0; i < NV; i++) begin
         send_req(VECS[i].tgt, VECS[i].pred);
         if (VECS[i].dst == 2'd0) begin
            quiet(3, 2'd0, $sformatf("R5/R8/R10 vector %0d stays RUN", i));
         end else begin
            expect_trans((VECS[i].dst == 2'd1) ? L_RI : L_RS, 2'd0, VECS[i].dst,
                         $sformatf("R2/R3/R4/R5/R8 vector %0d entry", i));
            if (VECS[i].dst == 2'd1) begin
               pulse_irq();
               expect_trans(L_IR, 2'd1, 2'd0, $sformatf("R6 vector %0d return", i));
            end else begin
               pulse_wake();
               expect_trans(L_SR, 2'd2, 2'd0, $sformatf("R7 vector %0d return", i));
            end
            @(negedge clk);
         end
      end

      // IDLE ignores wake and new requests; only irq leaves
      send_req(2'd1, 16'd100);
      expect_trans(L_RI, 2'd0, 2'd1, "R3 enter IDLE");
      pulse_wake();
      quiet(3, 2'd1, "R6 wake ignored in IDLE");
      send_req(2'd2, 16'd100);
      quiet(3, 2'd1, "R10 request ignored in IDLE");
      pulse_irq();
      expect_trans(L_IR, 2'd1, 2'd0, "R6 irq leaves IDLE");
      @(negedge clk);
      quiet(3, 2'd0, "R10 discarded request not replayed");

      // SLEEP ignores irq; only wake leaves
      send_req(2'd2, 16'd100);
      expect_trans(L_RS, 2'd0, 2'd2, "R4 enter SLEEP");
      pulse_irq();
      quiet(3, 2'd2, "R7 irq ignored in SLEEP");
      pulse_wake();
      expect_trans(L_SR, 2'd2, 2'd0, "R7 wake leaves SLEEP");
      @(negedge clk);

      // Request held during a transition
      send_req(2'd1, 16'd100);
      expect_trans(L_RI, 2'd0, 2'd1, "R9 setup IDLE");
      irq = 1'b1;
      @(negedge clk);
      irq        = 1'b0;
      req_valid  = 1'b1;
      req_target = 2'd2;
      pred_idle  = 16'd50;
      chk(1'b1, 2'd1, "R9 request during busy");
      @(negedge clk);
      req_valid = 1'b0;
      expect_trans(L_IR - 1, 2'd1, 2'd0, "R9 return to RUN");
      @(negedge clk);
      expect_trans(L_RS, 2'd0, 2'd2, "R9 held request enters SLEEP");
      pulse_wake();
      expect_trans(L_SR, 2'd2, 2'd0, "R9 wake after held request");
      @(negedge clk);
      quiet(3, 2'd0, "R9 hold cleared after use");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule